// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

A combinational shifter for 32-bit data that performs left logical, right logical and right arithmetic shifts. The amount is taken from one of two sources: a 5-bit constant field carried with the operation, or the low bits of a full-width register operand. A select input chooses between them for each operation. The result appears on the output in the same cycle, with no register in the path.

The datapath is a single cascade of 2:1 multiplexer levels, one level per amount bit. Level k moves the word right by 2^k positions when amount bit k is set. Left shifts use the same cascade: the bits of the input word are mirrored before it, and the bits of the result are mirrored after it. The fill bit entering from the top is 0 for logical shifts. For arithmetic shifts it is the sign bit of the data.

Top module: `shift_log_unit`

## Requirements
- R1: With op_i = 2'b00 (left logical), result_o equals data_i shifted left by the selected amount, and the vacated low positions are 0.
- R2: With op_i = 2'b01 (right logical), result_o equals data_i shifted right by the selected amount, and the vacated high positions are 0.
- R3: With op_i = 2'b10 (right arithmetic), result_o equals data_i shifted right by the selected amount, and the vacated high positions are copies of data_i bit 31.
- R4: A selected amount of 0 returns data_i unchanged for every op_i value.
- R5: With var_sel_i = 0, the amount is imm_amt_i, which covers 0 to 31. reg_amt_i has no effect on result_o.
- R6: With var_sel_i = 1, the amount is reg_amt_i[4:0]. Bits 31:5 of reg_amt_i and all of imm_amt_i have no effect on result_o.
- R7: op_i = 2'b11 behaves as a right logical shift.
- R8: The block is purely combinational. result_o follows a change on any input without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to be shifted |
| op_i | input | 2 | Shift type: 00 left logical, 01 right logical, 10 right arithmetic, 11 right logical |
| var_sel_i | input | 1 | 0: amount from imm_amt_i; 1: amount from reg_amt_i |
| imm_amt_i | input | 5 | Constant shift amount |
| reg_amt_i | input | 32 | Register operand; only its low 5 bits give the amount |
| result_o | output | 32 | Shifted word |

## Verification
The case that is hardest to reach from the ports is an amount source that is selected but wrong. That fault is invisible whenever the unselected source happens to carry the same amount. To expose it, every vector puts a different amount in the unselected source, and it also sets the ignored high bits of reg_amt_i to nonzero values. Arithmetic fill is only visible when bit 31 of the data is 1. For that reason the data patterns include both signs, plus single-bit and alternating words. These patterns are swept across all 32 amounts, all four op codes and both amount sources.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LEFT_LOG  = 2'b00,
    SH_RIGHT_LOG = 2'b01,
    SH_RIGHT_ARI = 2'b10,
    SH_RIGHT_ALT = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              var_sel_i,
  input  logic [AMT_W-1:0]  imm_amt_i,
  input  logic [DATA_W-1:0] reg_amt_i,
  output logic [AMT_W-1:0]  amt_o
);
  // upper register bits carry no amount information
  logic unused_reg_hi;
  assign unused_reg_hi = ^reg_amt_i[DATA_W-1:AMT_W];

  assign amt_o = var_sel_i ? reg_amt_i[AMT_W-1:0] : imm_amt_i;
endmodule

// File: rtl/shift_bit_rev.sv
module shift_bit_rev #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign q_o[i] = d_i[DATA_W-1-i];
  end
endmodule

// File: rtl/shift_right_cascade.sv
module shift_right_cascade #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] stage [AMT_W+1];

  assign stage[0] = d_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
    localparam int SH = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{SH{fill_i}}, stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign q_o = stage[AMT_W];

  // R3: any nonzero shift with fill set must leave the top bit set
  always_comb begin
    if (!$isunknown({amt_i, fill_i, q_o}) && fill_i && (amt_i != '0))
      a_r3_fill_reaches_msb: assert (q_o[DATA_W-1] == 1'b1);
  end
endmodule

// File: rtl/shift_log_unit.sv
module shift_log_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        op_i,
  input  logic              var_sel_i,
  input  logic [AMT_W-1:0]  imm_amt_i,
  input  logic [DATA_W-1:0] reg_amt_i,
  output logic [DATA_W-1:0] result_o
);
  shift_op_e         op;
  logic              is_left;
  logic              fill;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] data_rev, core_in, core_out, out_rev;

  assign op      = shift_op_e'(op_i);
  assign is_left = (op == SH_LEFT_LOG);
  assign fill    = (op == SH_RIGHT_ARI) & data_i[DATA_W-1];

  shift_amt_sel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_amt_sel (
    .var_sel_i (var_sel_i),
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .amt_o     (amt)
  );

  shift_bit_rev #(.DATA_W(DATA_W)) u_rev_in (
    .d_i (data_i),
    .q_o (data_rev)
  );

  assign core_in = is_left ? data_rev : data_i;

  shift_right_cascade #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_cascade (
    .d_i    (core_in),
    .amt_i  (amt),
    .fill_i (fill),
    .q_o    (core_out)
  );

  shift_bit_rev #(.DATA_W(DATA_W)) u_rev_out (
    .d_i (core_out),
    .q_o (out_rev)
  );

  assign result_o = is_left ? out_rev : core_out;

  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << amt) - DATA_W'(1);

  always_comb begin
    if (!$isunknown({data_i, op_i, amt, result_o})) begin
      // R4: zero amount is a pass-through
      if (amt == '0)
        a_r4_zero_pass: assert (result_o == data_i);
      // R1: left shift clears the vacated low bits
      if (op == SH_LEFT_LOG)
        a_r1_low_zero: assert ((result_o & low_mask) == '0);
      // R2, R7: logical shifts never create ones
      if (op != SH_RIGHT_ARI)
        a_r2_no_new_ones: assert ($countones(result_o) <= $countones(data_i));
      // R3: arithmetic shift keeps the sign
      if (op == SH_RIGHT_ARI)
        a_r3_sign_kept: assert (result_o[DATA_W-1] == data_i[DATA_W-1]);
    end
  end
endmodule

// File: tb/shift_log_unit_bench.sv
module shift_log_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] data;
  logic [1:0]  op;
  logic        var_sel;
  logic [4:0]  imm_amt;
  logic [31:0] reg_amt;
  logic [31:0] result;

  int n_vec;
  int n_bad;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  shift_log_unit u_shift_log_unit (
    .data_i    (data),
    .op_i      (op),
    .var_sel_i (var_sel),
    .imm_amt_i (imm_amt),
    .reg_amt_i (reg_amt),
    .result_o  (result)
  );

  task automatic check(input string req, input logic [31:0] exp);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d vsel=%0b imm=%0d reg=%h data=%h actual=%h expected=%h",
               req, op, var_sel, imm_amt, reg_amt, data, result, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] d, input logic [1:0] o,
                                         input int a);
    case (o)
      2'b00:   return d << a;
      2'b10:   return 32'($signed(d) >>> a);
      default: return d >> a;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] o, input int a, input logic vs);
    string s;
    case (o)
      2'b00:   s = "R1";
      2'b01:   s = "R2";
      2'b10:   s = "R3";
      default: s = "R7";
    endcase
    if (a == 0) s = {s, "/R4"};
    s = vs ? {s, "/R6"} : {s, "/R5"};
    return s;
  endfunction

  logic [31:0] pats [10];

  initial begin
    n_vec = 0;
    n_bad = 0;
    rst_n = 1'b0;
    data = '0; op = '0; var_sel = 1'b0; imm_amt = '0; reg_amt = '0;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
    pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h7FFF_FFFF;
    pats[6] = 32'h8000_0001; pats[7] = 32'h1234_5678;
    pats[8] = 32'hDEAD_BEEF; pats[9] = 32'h5555_5555;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R4 reset-state", 32'h0);
    rst_n = 1'b1;

    for (int p = 0; p < 10; p++) begin
      for (int o = 0; o < 4; o++) begin
        for (int a = 0; a < 32; a++) begin
          for (int vs = 0; vs < 2; vs++) begin
            @(negedge clk);
            data    = pats[p];
            op      = 2'(o);
            var_sel = 1'(vs);
            if (vs == 1) begin
              // R6: junk high bits and a mismatched constant must not matter
              reg_amt = {27'(32'h5A5A_5A5A + 32'(p * 7 + a)), 5'(a)};
              imm_amt = 5'(31 - a);
            end else begin
              // R5: register operand carries a different amount
              imm_amt = 5'(a);
              reg_amt = {27'(32'h3C3C_3C3C ^ 32'(a)), 5'(a + 11)};
            end
            #1;
            check(tag(2'(o), a, 1'(vs)), model(pats[p], 2'(o), a));
          end
        end
      end
    end

    // R8: result follows inputs between clock edges
    @(posedge clk);
    #0.5;
    data = 32'hF000_000F; op = 2'b10; var_sel = 1'b0; imm_amt = 5'd4;
    #0.5;
    check("R8 comb-follow-a", 32'hFF00_0000);
    imm_amt = 5'd31;
    #0.5;
    check("R8 comb-follow-b", 32'hFFFF_FFFF);
    op = 2'b00;
    #0.5;
    check("R8 comb-follow-c", 32'h8000_0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule